// File: doc/BRIEF.md
# Bus Parity Machine-Check Capture Unit

This unit sits beside a processor's external bus interface and watches the data phase of read cycles. A cycle begins with a start strobe that carries the physical address and a three-bit cycle code. Each data-ready strobe of an eligible read cycle samples the parity-enable input. When a data parity error is flagged at that strobe and parity enable is high, the unit stores the address and code of the failing cycle in two 64-bit capture registers. If the machine-check enable bit is set, it also raises a one-cycle request for exception vector 0x12.

Sampling is suppressed for write and special cycles, for any low-power or stopped state, while the bus is backed off, handed to another master or in init, and during address hold for cycles that began while the hold was already active. A rising bus-error input raises the same exception request under the same enable bit, but it never touches the capture registers. Software reads the captures through a one-bit register select.

Top module: `parity_mc_capture`

## Requirements
- R1: After reset both capture registers read zero, and `excReq` and `excVector` are zero.
- R2: At a data-ready strobe of an eligible cycle that shows `parityErr`=1 and `parityEn`=1, the address register takes the zero-extended address presented at that cycle's start, and the type register takes the cycle code in bits [2:0] with all upper bits zero. Cycle codes: 0 memory read, 1 I/O read, 2 locked read, 3 interrupt acknowledge, 4 memory write, 5 I/O write, 6 locked write, 7 special.
- R3: A strobe with `parityEn`=0 captures nothing and requests nothing, even with `parityErr`=1.
- R4: Cycles whose code has bit 2 set (codes 4 to 7) are never sampled.
- R5: Sampling happens only when `pwrState` is 0 (running). Values 1 shutdown, 2 halt, 3 stop-grant and 4 stop-clock suppress it.
- R6: Sampling is suppressed while `backoff`, `holdAck` or `initIn` is high.
- R7: While `addrHold` is high, only a cycle that started with `addrHold` low is sampled.
- R8: A capture raises `excReq` for exactly one cycle, on the clock after the sampling edge, only if `mceEnable` was 1 at that edge. `excVector` reads 0x12 during the pulse and 0 otherwise.
- R9: A rising edge on `busErr` with `mceEnable`=1 gives a one-cycle `excReq` on the next clock. A level held high gives no further pulse. The capture registers are left unchanged.
- R10: `msrData` shows the address register when `msrSel`=0 and the type register when `msrSel`=1, with no clock delay.
- R11: A cycle stays open until a strobe with `lastBeat`=1. Strobes outside an open cycle are ignored. The stored address is the one presented at the start, even if `cycAddr` changes later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycStart | input | 1 | First clock of a bus cycle |
| cycAddr | input | ADDR_W | Physical address, valid with cycStart |
| cycCode | input | 3 | Cycle code, valid with cycStart |
| readyStrobe | input | 1 | Data-ready strobe |
| lastBeat | input | 1 | Strobe is the last of the cycle |
| parityErr | input | 1 | Data parity error flag |
| parityEn | input | 1 | Parity enable from system logic |
| busErr | input | 1 | Bus error input |
| addrHold | input | 1 | Address hold |
| backoff | input | 1 | Bus backoff |
| holdAck | input | 1 | Hold acknowledge |
| initIn | input | 1 | Init in progress |
| pwrState | input | 3 | Power state code |
| mceEnable | input | 1 | Machine-check enable bit |
| msrSel | input | 1 | Capture register select |
| msrData | output | 64 | Selected capture register |
| excReq | output | 1 | Machine-check request pulse |
| excVector | output | 8 | Vector number during request |

## Verification
On every cycle, the assertions check four things: a request never appears unless the enable bit was set on the edge before, the address register changes only after a capture strobe, a captured cycle never has a write or special code, and a cycle that began under address hold is never sampled while the hold stays high. The interplay of code, power state, bus-ownership signals, hold timing, parity enable and enable bit can only be shown by the bench's sweep over all their combinations. The bench checks the register contents and the pulse timing against expected values it computes itself. The bus-error edge behaviour, multi-beat cycles and strobes outside a cycle are shown only by directed scenarios.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int CODE_W = 3;
  localparam int PWR_W  = 3;

  typedef enum logic [CODE_W-1:0] {
    CYC_MEM_RD  = 3'd0,
    CYC_IO_RD   = 3'd1,
    CYC_LOCK_RD = 3'd2,
    CYC_INTA    = 3'd3,
    CYC_MEM_WR  = 3'd4,
    CYC_IO_WR   = 3'd5,
    CYC_LOCK_WR = 3'd6,
    CYC_SPECIAL = 3'd7
  } cyc_code_e;

  localparam logic [PWR_W-1:0] PWR_RUN = 3'd0;

  typedef struct packed {
    logic loadCycle;
    logic captureErr;
  } pmc_strobe_t;
endpackage

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycStart,
  input  logic [CODE_W-1:0] cycCode,
  input  logic              readyStrobe,
  input  logic              lastBeat,
  input  logic              parityErr,
  input  logic              parityEn,
  input  logic              busErr,
  input  logic              addrHold,
  input  logic              backoff,
  input  logic              holdAck,
  input  logic              initIn,
  input  logic [PWR_W-1:0]  pwrState,
  input  logic              mceEnable,
  output pmc_strobe_t       strobes,
  output logic              excReq
);
  logic cycActive;
  logic heldAtStart;
  logic cycReadable;
  logic busErrQ;
  logic busRise;
  logic busQuiet;
  logic sampleOk;
  logic captureNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycActive   <= 1'b0;
      heldAtStart <= 1'b0;
      cycReadable <= 1'b0;
    end else if (cycStart) begin
      cycActive   <= 1'b1;
      heldAtStart <= addrHold;
      cycReadable <= ~cycCode[CODE_W-1];
    end else if (cycActive && readyStrobe && lastBeat) begin
      cycActive <= 1'b0;
    end
  end

  always_comb begin
    busQuiet   = !backoff && !holdAck && !initIn;
    sampleOk   = cycActive && readyStrobe && cycReadable &&
                 (pwrState == PWR_RUN) && busQuiet &&
                 !(addrHold && heldAtStart);
    captureNow = sampleOk && parityErr && parityEn;
    busRise    = busErr && !busErrQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busErrQ <= 1'b0;
      excReq  <= 1'b0;
    end else begin
      busErrQ <= busErr;
      excReq  <= mceEnable && (captureNow || busRise);
    end
  end

  assign strobes.loadCycle  = cycStart;
  assign strobes.captureErr = captureNow;

  assert_exc_needs_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> $past(mceEnable));

  assert_hold_blocks_late_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cycStart && addrHold) && addrHold && !$past(!rstN)) |-> !captureNow);
endmodule

// File: rtl/pmc_dpath.sv
module pmc_dpath
  import pmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  pmc_strobe_t       strobes,
  input  logic [ADDR_W-1:0] cycAddr,
  input  logic [CODE_W-1:0] cycCode,
  input  logic              msrSel,
  output logic [REG_W-1:0]  msrData
);
  localparam int ADDR_PAD = REG_W - ADDR_W;
  localparam int TYPE_PAD = REG_W - CODE_W;

  logic [ADDR_W-1:0] curAddr;
  logic [CODE_W-1:0] curCode;
  logic [REG_W-1:0]  addrRegQ;
  logic [REG_W-1:0]  typeRegQ;
  logic [REG_W-1:0]  addrWide;

  generate
    if (ADDR_PAD > 0) begin : g_pad
      assign addrWide = {{ADDR_PAD{1'b0}}, curAddr};
    end else begin : g_trunc
      assign addrWide = curAddr[REG_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      curCode <= '0;
    end else if (strobes.loadCycle) begin
      curAddr <= cycAddr;
      curCode <= cycCode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrRegQ <= '0;
      typeRegQ <= '0;
    end else if (strobes.captureErr) begin
      addrRegQ <= addrWide;
      typeRegQ <= {{TYPE_PAD{1'b0}}, curCode};
    end
  end

  assign msrData = msrSel ? typeRegQ : addrRegQ;

  assert_addr_changes_on_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(addrRegQ) |-> $past(strobes.captureErr));

  assert_no_write_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureErr |-> !curCode[CODE_W-1]);
endmodule

// File: rtl/parity_mc_capture.sv
module parity_mc_capture
  import pmc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int REG_W     = 64,
  parameter int VEC_W     = 8,
  parameter int MC_VECTOR = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycStart,
  input  logic [ADDR_W-1:0] cycAddr,
  input  logic [2:0]        cycCode,
  input  logic              readyStrobe,
  input  logic              lastBeat,
  input  logic              parityErr,
  input  logic              parityEn,
  input  logic              busErr,
  input  logic              addrHold,
  input  logic              backoff,
  input  logic              holdAck,
  input  logic              initIn,
  input  logic [2:0]        pwrState,
  input  logic              mceEnable,
  input  logic              msrSel,
  output logic [REG_W-1:0]  msrData,
  output logic              excReq,
  output logic [VEC_W-1:0]  excVector
);
  localparam logic [VEC_W-1:0] VEC_VAL = VEC_W'(MC_VECTOR);

  pmc_strobe_t strobes;

  pmc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cycStart   (cycStart),
    .cycCode    (cycCode),
    .readyStrobe(readyStrobe),
    .lastBeat   (lastBeat),
    .parityErr  (parityErr),
    .parityEn   (parityEn),
    .busErr     (busErr),
    .addrHold   (addrHold),
    .backoff    (backoff),
    .holdAck    (holdAck),
    .initIn     (initIn),
    .pwrState   (pwrState),
    .mceEnable  (mceEnable),
    .strobes    (strobes),
    .excReq     (excReq)
  );

  pmc_dpath #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .cycAddr(cycAddr),
    .cycCode(cycCode),
    .msrSel (msrSel),
    .msrData(msrData)
  );

  assign excVector = excReq ? VEC_VAL : '0;
endmodule

// File: tb/tb_parity_mc_capture.sv
`timescale 1ns/1ps
module tb_parity_mc_capture;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cycStart, readyStrobe, lastBeat, parityErr, parityEn, busErr;
  logic        addrHold, backoff, holdAck, initIn, mceEnable, msrSel;
  logic [31:0] cycAddr;
  logic [2:0]  cycCode, pwrState;
  logic [63:0] msrData;
  logic        excReq;
  logic [7:0]  excVector;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  logic [63:0] expAddr, expType;

  always #4 clk = ~clk;

  parity_mc_capture dut (
    .clk(clk), .rstN(rstN), .cycStart(cycStart), .cycAddr(cycAddr),
    .cycCode(cycCode), .readyStrobe(readyStrobe), .lastBeat(lastBeat),
    .parityErr(parityErr), .parityEn(parityEn), .busErr(busErr),
    .addrHold(addrHold), .backoff(backoff), .holdAck(holdAck),
    .initIn(initIn), .pwrState(pwrState), .mceEnable(mceEnable),
    .msrSel(msrSel), .msrData(msrData), .excReq(excReq), .excVector(excVector)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkRegs(input string req);
    msrSel = 1'b0; #1;
    chk({req, " R10 addr"}, msrData, expAddr);
    msrSel = 1'b1; #1;
    chk({req, " R10 type"}, msrData, expType);
  endtask

  task automatic idle();
    cycStart = 0; readyStrobe = 0; lastBeat = 0; parityErr = 0; parityEn = 0;
    busErr = 0; addrHold = 0; backoff = 0; holdAck = 0; initIn = 0;
    pwrState = 3'd0; mceEnable = 0; msrSel = 0; cycAddr = '0; cycCode = '0;
  endtask

  // holdMode: 0 no hold, 1 hold before start and kept, 2 hold raised after start
  task automatic runVec(input int code, input int pwr, input int blk, input int hm,
                        input bit pen, input bit perr, input bit mce, input logic [31:0] a);
    bit elig, cap;
    @(negedge clk);
    cycStart = 1; cycAddr = a; cycCode = 3'(code); addrHold = (hm == 1);
    pwrState = 3'(pwr); backoff = blk[0]; holdAck = blk[1]; initIn = blk[2];
    @(negedge clk);
    cycStart = 0; cycAddr = ~a; cycCode = 3'd7; addrHold = (hm != 0);
    readyStrobe = 1; lastBeat = 1; parityErr = perr; parityEn = pen; mceEnable = mce;
    @(negedge clk);
    readyStrobe = 0; lastBeat = 0; parityErr = 0; parityEn = 0; addrHold = 0;
    // R4 R5 R6 R7 R3: eligibility computed from requirement text
    elig = (code < 4) && (pwr == 0) && (blk == 0) && (hm != 1);
    cap  = elig && pen && perr;
    if (cap) begin
      expAddr = {32'd0, a};
      expType = {61'd0, 3'(code)};
    end
    chk("R8 R3 R4 R5 R6 R7 excReq", {63'd0, excReq}, {63'd0, cap && mce});
    chk("R8 excVector", {56'd0, excVector}, (cap && mce) ? 64'h12 : 64'h0);
    checkRegs("R2 R11");
    mceEnable = 0;
    @(negedge clk);
    chk("R8 single pulse", {63'd0, excReq}, 64'd0);
  endtask

  initial begin
    int idx;
    idle();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    expAddr = '0; expType = '0;
    chk("R1 excReq", {63'd0, excReq}, 64'd0);
    chk("R1 excVector", {56'd0, excVector}, 64'd0);
    checkRegs("R1");

    idx = 1;
    for (int code = 0; code < 8; code++)
      for (int pwr = 0; pwr < 5; pwr++)
        for (int blk = 0; blk < 8; blk++)
          for (int hm = 0; hm < 3; hm++)
            for (int bits = 0; bits < 8; bits++) begin
              runVec(code, pwr, blk, hm, bits[0], bits[1], bits[2],
                     {16'(idx), ~16'(idx)} ^ 32'h5A00_00A5);
              idx++;
            end
    idle();

    // R11: strobes after the cycle ended are ignored
    @(negedge clk);
    readyStrobe = 1; lastBeat = 1; parityErr = 1; parityEn = 1; mceEnable = 1;
    @(negedge clk);
    readyStrobe = 0; parityErr = 0; parityEn = 0;
    chk("R11 stray strobe excReq", {63'd0, excReq}, 64'd0);
    checkRegs("R11 stray strobe");
    mceEnable = 0;

    // R11: multi-beat, error on the fourth beat, address changed mid-cycle
    @(negedge clk);
    cycStart = 1; cycAddr = 32'hCAFE_0040; cycCode = 3'd2; mceEnable = 1;
    @(negedge clk);
    cycStart = 0; cycAddr = 32'h1111_1111;
    for (int b = 0; b < 4; b++) begin
      readyStrobe = 1; lastBeat = (b == 3); parityEn = 1; parityErr = (b == 3);
      @(negedge clk);
    end
    readyStrobe = 0; lastBeat = 0; parityErr = 0; parityEn = 0;
    expAddr = 64'h0000_0000_CAFE_0040; expType = 64'd2;
    chk("R11 burst excReq", {63'd0, excReq}, 64'd1);
    checkRegs("R11 burst");
    mceEnable = 0;

    // R9: bus error edge with enable, held level, then without enable
    @(negedge clk);
    busErr = 1; mceEnable = 1;
    @(negedge clk);
    chk("R9 busErr pulse", {63'd0, excReq}, 64'd1);
    chk("R9 vector", {56'd0, excVector}, 64'h12);
    @(negedge clk);
    chk("R9 held level no repeat", {63'd0, excReq}, 64'd0);
    @(negedge clk);
    chk("R9 held level no repeat 2", {63'd0, excReq}, 64'd0);
    checkRegs("R9 regs untouched");
    busErr = 0; mceEnable = 0;
    @(negedge clk);
    busErr = 1;
    @(negedge clk);
    chk("R9 disabled no pulse", {63'd0, excReq}, 64'd0);
    busErr = 0;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule